// File: doc/BRIEF.md
# Inter-Processor Message Mailbox

This block lets several processors on one chip pass 32-bit words to each other through a set of small hardware queues. The block is a memory-mapped slave. For each queue it offers three words: a data word, a full flag and an occupancy count. Writing the data word adds a message to the queue, and reading it removes the oldest message.

Every queue produces two events: one when a message arrives and one when a queue that was full gives up an entry. Each event is latched into a separate status word for every user. Software clears a status bit by writing a one to it. Each user has an enable mask, and that user's interrupt line is the OR over the enabled, pending bits. A configuration word holds idle-policy fields and a self-clearing reset request. A status word reports when that reset has finished, and a read-only word gives the version.

The bus protocol is a single-cycle access. With `bus_sel` high during a clock cycle, a write commits on the rising edge. A read returns its data combinationally in the same cycle, and any side effect it has (a pop) takes place on that same edge.

Top module: `mbx_top`

## Requirements
- R1: A write to the data word of queue m (byte address 0x040 + 4*m) appends the write data. A read of it returns and removes the oldest entry, so entries come out in first-in first-out order. The count word at 0x0C0 + 4*m reads the number of stored entries, from 0 to 4.
- R2: The full word at 0x080 + 4*m reads 1 when the queue holds 4 entries and reads 0 otherwise. A write to a full queue is discarded.
- R3: A read of the data word of an empty queue returns zero. It changes no count and no status bit.
- R4: Each accepted write to queue m sets bit 2*m in the status word of every user.
- R5: A read that takes queue m from 4 entries to 3 sets bit 2*m+1 in the status word of every user. Reads that start below 4 entries do not set it.
- R6: The status word of user u is at 0x100 + 8*u. Writing it clears each bit where the write data has a one and leaves every bit where the write data has a zero.
- R7: The enable word of user u is at 0x104 + 8*u and keeps only the low 8 bits of the write data. Output `irq_o[u]` is high exactly when some bit is set in both the status and the enable word of user u.
- R8: Writing the configuration word (0x010) with bit 1 set starts a reset sequence that lasts 4 cycles. During the sequence, bit 1 of the configuration word reads 1 and bit 0 of the reset status word (0x014) reads 0. The sequence empties every queue and clears every status and enable word. When it ends, bit 1 reads 0 and the reset-done bit reads 1.
- R9: The configuration word stores an automatic-idle flag in bit 0 and a 2-bit idle policy in bits 4:3, and reads them back. The reset sequence keeps both fields. The word at 0x000 reads 0x10, with major version 1 in bits 7:4 and minor version 0 in bits 3:0.
- R10: Reads of unmapped or misaligned byte addresses return zero. Writes to those addresses change nothing.
- R11: After the reset input is released, every queue is empty, every status and enable word is zero, all interrupt lines are low, the configuration word is zero, and reset-done reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 4 | Interrupt line for each user |

## Verification
Every queue in turn is filled past capacity and then drained past empty. This separates correct ordering and count stepping from two faults: an overflow write that overwrites an entry, and an underflow read that moves a pointer. Within each such sweep the two event bits are checked in every user's status word. This shows whether events reach the right bit position and whether the not-full event fires only on a pop from a full queue. For each user, a single pending bit is tried against a matching enable mask and against its complement, which exposes crossed interrupt lines or a missing AND. Clear writes of zero and of a one in a single position show whether the clear leaves other bits alone.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int OFS_VERSION  = 'h000;
    localparam int OFS_CONFIG   = 'h010;
    localparam int OFS_RSTSTAT  = 'h014;
    localparam int OFS_DATA     = 'h040;
    localparam int OFS_FULLFLAG = 'h080;
    localparam int OFS_LEVEL    = 'h0C0;
    localparam int OFS_USER     = 'h100;
    localparam int USER_STRIDE  = 8;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_VERSION,
        RG_CONFIG,
        RG_RSTSTAT,
        RG_DATA,
        RG_FULLFLAG,
        RG_LEVEL,
        RG_PEND,
        RG_MASK
    } region_e;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int AW = 9,
    parameter int NQ = 4,
    parameter int NU = 4,
    parameter int IW = 2
) (
    input  logic [AW-1:0] addr,
    output region_e       region,
    output logic [IW-1:0] index
);

    logic [AW-1:0] off_q_data;
    logic [AW-1:0] off_q_full;
    logic [AW-1:0] off_q_lvl;
    logic [AW-1:0] off_user;

    assign off_q_data = addr - AW'(OFS_DATA);
    assign off_q_full = addr - AW'(OFS_FULLFLAG);
    assign off_q_lvl  = addr - AW'(OFS_LEVEL);
    assign off_user   = addr - AW'(OFS_USER);

    always_comb begin
        region = RG_NONE;
        index  = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr == AW'(OFS_VERSION)) begin
                region = RG_VERSION;
            end else if (addr == AW'(OFS_CONFIG)) begin
                region = RG_CONFIG;
            end else if (addr == AW'(OFS_RSTSTAT)) begin
                region = RG_RSTSTAT;
            end else if (addr >= AW'(OFS_DATA) && addr < AW'(OFS_DATA + 4 * NQ)) begin
                region = RG_DATA;
                index  = off_q_data[2 +: IW];
            end else if (addr >= AW'(OFS_FULLFLAG) && addr < AW'(OFS_FULLFLAG + 4 * NQ)) begin
                region = RG_FULLFLAG;
                index  = off_q_full[2 +: IW];
            end else if (addr >= AW'(OFS_LEVEL) && addr < AW'(OFS_LEVEL + 4 * NQ)) begin
                region = RG_LEVEL;
                index  = off_q_lvl[2 +: IW];
            end else if (addr >= AW'(OFS_USER) && addr < AW'(OFS_USER + USER_STRIDE * NU)) begin
                region = off_user[2] ? RG_MASK : RG_PEND;
                index  = off_user[3 +: IW];
            end
        end
    end

endmodule

// File: rtl/mbx_queue.sv
module mbx_queue #(
    parameter  int DW    = 32,
    parameter  int DEPTH = 4,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          notfull_ev
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            rd;
        logic [PW-1:0]            wp;
        logic [CW-1:0]            cnt;
    } q_state_t;

    q_state_t st_d, st_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full       = (st_q.cnt == CW'(DEPTH));
    assign push_ok    = push && !full && !clr;
    assign pop_ok     = pop && (st_q.cnt != '0) && !clr;
    assign notfull_ev = pop_ok && full;
    assign head       = st_q.mem[st_q.rd];
    assign count      = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.rd  = '0;
            st_d.wp  = '0;
            st_d.cnt = '0;
        end else begin
            if (push_ok) begin
                st_d.mem[st_q.wp] = wdata;
                st_d.wp           = step(st_q.wp);
                st_d.cnt          = st_q.cnt + CW'(1);
            end
            if (pop_ok) begin
                st_d.rd  = step(st_q.rd);
                st_d.cnt = st_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mbx_irq_bank.sv
module mbx_irq_bank #(
    parameter int NU = 4,
    parameter int NQ = 4,
    parameter int DW = 32,
    parameter int IW = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic [NQ-1:0]          ev_new,
    input  logic [NQ-1:0]          ev_notfull,
    input  logic                   wr_en,
    input  logic                   wr_mask,
    input  logic [IW-1:0]          wr_user,
    input  logic [DW-1:0]          wdata,
    output logic [NU-1:0][DW-1:0]  pend_o,
    output logic [NU-1:0][DW-1:0]  mask_o,
    output logic [NU-1:0]          irq_o
);

    localparam int NB = 2 * NQ;

    typedef struct packed {
        logic [NU-1:0][DW-1:0] pend;
        logic [NU-1:0][DW-1:0] mask;
    } bank_t;

    bank_t bk_d, bk_q;
    logic [DW-1:0] ev_vec;
    logic [DW-1:0] valid_bits;

    // R4/R5: event bit layout, arrival on even bits and not-full on odd bits
    for (genvar q = 0; q < NQ; q++) begin : g_ev
        assign ev_vec[2*q]   = ev_new[q];
        assign ev_vec[2*q+1] = ev_notfull[q];
    end
    if (NB < DW) begin : g_ev_pad
        assign ev_vec[DW-1:NB] = '0;
    end

    for (genvar b = 0; b < DW; b++) begin : g_valid
        assign valid_bits[b] = (b < NB);
    end

    always_comb begin
        bk_d = bk_q;
        for (int u = 0; u < NU; u++) begin
            if (clr) begin
                bk_d.pend[u] = '0;
                bk_d.mask[u] = '0;
            end else begin
                if (wr_en && !wr_mask && wr_user == IW'(u)) begin
                    bk_d.pend[u] = bk_q.pend[u] & ~wdata;
                end
                bk_d.pend[u] = bk_d.pend[u] | ev_vec;
                if (wr_en && wr_mask && wr_user == IW'(u)) begin
                    bk_d.mask[u] = wdata & valid_bits;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign pend_o = bk_q.pend;
    assign mask_o = bk_q.mask;

    for (genvar u = 0; u < NU; u++) begin : g_irq
        assign irq_o[u] = |(bk_q.pend[u] & bk_q.mask[u]);
    end

endmodule

// File: rtl/mbx_sysctl.sv
module mbx_sysctl #(
    parameter int SRST_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       wr_autoidle,
    input  logic       wr_reset_req,
    input  logic [1:0] wr_idle,
    output logic       busy,
    output logic       done,
    output logic       autoidle,
    output logic [1:0] idle_mode
);

    localparam int TW = (SRST_CYCLES > 1) ? $clog2(SRST_CYCLES) : 1;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [TW-1:0] timer;
        logic          autoidle;
        logic [1:0]    idle;
    } sys_t;

    sys_t sy_d, sy_q;

    always_comb begin
        sy_d = sy_q;
        if (sy_q.busy) begin
            if (sy_q.timer == '0) begin
                sy_d.busy = 1'b0;
                sy_d.done = 1'b1;
            end else begin
                sy_d.timer = sy_q.timer - TW'(1);
            end
        end else if (cfg_wr) begin
            sy_d.autoidle = wr_autoidle;
            sy_d.idle     = wr_idle;
            if (wr_reset_req) begin
                sy_d.busy  = 1'b1;
                sy_d.done  = 1'b0;
                sy_d.timer = TW'(SRST_CYCLES - 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '{busy: 1'b0, done: 1'b1, timer: '0, autoidle: 1'b0, idle: 2'b00};
        end else begin
            sy_q <= sy_d;
        end
    end

    assign busy      = sy_q.busy;
    assign done      = sy_q.done;
    assign autoidle  = sy_q.autoidle;
    assign idle_mode = sy_q.idle;

endmodule

// File: rtl/mbx_top.sv
module mbx_top
    import mbx_pkg::*;
#(
    parameter int NQ          = 4,
    parameter int NU          = 4,
    parameter int DEPTH       = 4,
    parameter int DW          = 32,
    parameter int AW          = 9,
    parameter int SRST_CYCLES = 4,
    parameter int VER_MAJOR   = 1,
    parameter int VER_MINOR   = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [NU-1:0] irq_o
);

    localparam int CW   = $clog2(DEPTH + 1);
    localparam int MAXN = (NQ > NU) ? NQ : NU;
    localparam int IW   = (MAXN > 1) ? $clog2(MAXN) : 1;

    region_e              region;
    logic [IW-1:0]        index;
    logic [NQ-1:0][DW-1:0] q_head;
    logic [NQ-1:0][CW-1:0] q_count_flat;
    logic [NQ-1:0]        q_full;
    logic [NQ-1:0]        q_push_ok;
    logic [NQ-1:0]        q_pop_ok;
    logic [NQ-1:0]        q_nf_ev;
    logic [NU-1:0][DW-1:0] irq_status;
    logic [NU-1:0][DW-1:0] irq_enable;
    logic                 sys_busy;
    logic                 sys_done;
    logic                 sys_autoidle;
    logic [1:0]           sys_idle;
    logic                 wr_access;
    logic                 rd_access;

    assign wr_access = bus_sel && bus_wr;
    assign rd_access = bus_sel && !bus_wr;

    mbx_decode #(.AW(AW), .NQ(NQ), .NU(NU), .IW(IW)) u_decode (
        .addr   (bus_addr),
        .region (region),
        .index  (index)
    );

    // R1/R2/R3: one queue per index, push on data write, pop on data read
    for (genvar q = 0; q < NQ; q++) begin : g_queue
        logic hit;
        assign hit = (region == RG_DATA) && (index == IW'(q));
        mbx_queue #(.DW(DW), .DEPTH(DEPTH)) u_queue (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (sys_busy),
            .push       (wr_access && hit),
            .pop        (rd_access && hit),
            .wdata      (bus_wdata),
            .head       (q_head[q]),
            .count      (q_count_flat[q]),
            .full       (q_full[q]),
            .push_ok    (q_push_ok[q]),
            .pop_ok     (q_pop_ok[q]),
            .notfull_ev (q_nf_ev[q])
        );
    end

    // R4..R7: per-user pending and mask words
    mbx_irq_bank #(.NU(NU), .NQ(NQ), .DW(DW), .IW(IW)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (sys_busy),
        .ev_new     (q_push_ok),
        .ev_notfull (q_nf_ev),
        .wr_en      (wr_access && (region == RG_PEND || region == RG_MASK)),
        .wr_mask    (region == RG_MASK),
        .wr_user    (index),
        .wdata      (bus_wdata),
        .pend_o     (irq_status),
        .mask_o     (irq_enable),
        .irq_o      (irq_o)
    );

    // R8/R9: reset sequencer and idle policy fields
    mbx_sysctl #(.SRST_CYCLES(SRST_CYCLES)) u_sys (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (wr_access && region == RG_CONFIG),
        .wr_autoidle  (bus_wdata[0]),
        .wr_reset_req (bus_wdata[1]),
        .wr_idle      (bus_wdata[4:3]),
        .busy         (sys_busy),
        .done         (sys_done),
        .autoidle     (sys_autoidle),
        .idle_mode    (sys_idle)
    );

    // R10: anything not decoded reads as zero
    always_comb begin
        bus_rdata = '0;
        unique case (region)
            RG_VERSION:  bus_rdata = DW'({VER_MAJOR[3:0], VER_MINOR[3:0]});
            RG_CONFIG:   bus_rdata = DW'({sys_idle, 1'b0, sys_busy, sys_autoidle});
            RG_RSTSTAT:  bus_rdata = DW'(sys_done);
            RG_DATA:     bus_rdata = (q_count_flat[index] != '0 && !sys_busy) ? q_head[index] : '0;
            RG_FULLFLAG: bus_rdata = DW'(q_full[index]);
            RG_LEVEL:    bus_rdata = DW'(q_count_flat[index]);
            RG_PEND:     bus_rdata = irq_status[index];
            RG_MASK:     bus_rdata = irq_enable[index];
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mbx_top_checker.sv
module mbx_top_checker #(
    parameter int NQ    = 4,
    parameter int NU    = 4,
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    parameter int AW    = 9,
    parameter int CW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_rdata,
    input logic [NU-1:0]    irq_o,
    input logic [NQ*CW-1:0] q_count_flat,
    input logic [NQ-1:0]    q_full,
    input logic [NQ-1:0]    q_push_ok,
    input logic [NU*DW-1:0] irq_status,
    input logic             sys_busy
);

    for (genvar q = 0; q < NQ; q++) begin : g_q
        // R1: occupancy never exceeds capacity
        p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
            q_count_flat[q*CW +: CW] <= CW'(DEPTH));

        // R2: a write into a full queue leaves the level untouched
        p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && bus_wr && bus_addr == AW'('h040 + 4*q) && q_full[q] && !sys_busy)
            |=> q_count_flat[q*CW +: CW] == $past(q_count_flat[q*CW +: CW]));

        // R3: reading an empty queue yields zero
        p_empty_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && !bus_wr && bus_addr == AW'('h040 + 4*q) && q_count_flat[q*CW +: CW] == '0)
            |-> bus_rdata == '0);

        for (genvar u = 0; u < NU; u++) begin : g_u
            // R4: an accepted write flags arrival for every user
            p_arrival_r4: assert property (@(posedge clk) disable iff (!rst_n)
                q_push_ok[q] |=> irq_status[u*DW + 2*q]);
        end
    end

    // R8: one cycle into the reset sequence every line is quiet
    p_quiet_in_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_busy |=> irq_o == '0);

endmodule

bind mbx_top mbx_top_checker #(
    .NQ(NQ), .NU(NU), .DEPTH(DEPTH), .DW(DW), .AW(AW), .CW(CW)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .irq_o        (irq_o),
    .q_count_flat (q_count_flat),
    .q_full       (q_full),
    .q_push_ok    (q_push_ok),
    .irq_status   (irq_status),
    .sys_busy     (sys_busy)
);

// File: tb/tb_mbx_top.sv
module tb_mbx_top;

    localparam int CLK_PERIOD = 10;
    localparam int NQ   = 4;
    localparam int NU   = 4;
    localparam int DEP  = 4;
    localparam int SRST = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_o;

    int n_checks = 0;
    int n_errors = 0;
    bit reported = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    function automatic logic [8:0] a_data(input int m);  return 9'('h040 + 4*m); endfunction
    function automatic logic [8:0] a_full(input int m);  return 9'('h080 + 4*m); endfunction
    function automatic logic [8:0] a_lvl(input int m);   return 9'('h0C0 + 4*m); endfunction
    function automatic logic [8:0] a_pend(input int u);  return 9'('h100 + 8*u); endfunction
    function automatic logic [8:0] a_mask(input int u);  return 9'('h104 + 8*u); endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
    endtask

    task automatic clear_all_pending();
        for (int u = 0; u < NU; u++) bwrite(a_pend(u), 32'hFFFF_FFFF);
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11: state after reset
        bread(9'h000, r); check("R9 version", r, 32'h10);
        bread(9'h014, r); check("R11 reset-done", r, 32'h1);
        bread(9'h010, r); check("R11 config", r, 32'h0);
        for (int m = 0; m < NQ; m++) begin
            bread(a_lvl(m), r);  check("R11 level", r, 32'h0);
            bread(a_full(m), r); check("R11 full", r, 32'h0);
        end
        for (int u = 0; u < NU; u++) begin
            bread(a_pend(u), r); check("R11 pending", r, 32'h0);
            bread(a_mask(u), r); check("R11 mask", r, 32'h0);
        end
        check("R11 irq", {28'h0, irq_o}, 32'h0);

        // R1..R5: fill past capacity then drain past empty, every queue
        for (int m = 0; m < NQ; m++) begin
            clear_all_pending();
            for (int k = 0; k <= DEP; k++) begin
                bwrite(a_data(m), 32'hA000_0000 + 32'(m*16 + k));
                bread(a_lvl(m), r);
                check("R1 level after write", r, 32'((k + 1 > DEP) ? DEP : k + 1));
                bread(a_full(m), r);
                check("R2 full flag", r, (k + 1 >= DEP) ? 32'h1 : 32'h0);
            end
            for (int u = 0; u < NU; u++) begin
                bread(a_pend(u), r);
                check("R4 arrival bit", r, 32'h1 << (2*m));
            end
            clear_all_pending();
            for (int u = 0; u < NU; u++) begin
                bread(a_pend(u), r);
                check("R6 cleared", r, 32'h0);
            end
            for (int k = 0; k < DEP; k++) begin
                bread(a_data(m), r);
                check("R1 fifo order", r, 32'hA000_0000 + 32'(m*16 + k));
                bread(a_pend(0), r);
                check("R5 not-full bit", r, 32'h1 << (2*m+1));
            end
            for (int u = 1; u < NU; u++) begin
                bread(a_pend(u), r);
                check("R5 not-full all users", r, 32'h1 << (2*m+1));
            end
            bread(a_data(m), r); check("R3 empty read", r, 32'h0);
            bread(a_lvl(m), r);  check("R3 level kept", r, 32'h0);
            bread(a_pend(2), r); check("R3 pending kept", r, 32'h1 << (2*m+1));
            bread(a_full(m), r); check("R2 not full", r, 32'h0);
        end

        // R6/R7: one pending bit against matching and complementary masks
        clear_all_pending();
        bwrite(a_data(1), 32'h5555_0001);
        for (int u = 0; u < NU; u++) begin
            bwrite(a_mask(u), 32'h1 << 2);
            #1 check("R7 irq matching mask", {28'h0, irq_o}, 32'h1 << u);
            bwrite(a_mask(u), ~(32'h1 << 2));
            bread(a_mask(u), r);
            check("R7 mask width", r, 32'h0000_00FB);
            check("R7 irq complementary mask", {28'h0, irq_o}, 32'h0);
            bwrite(a_mask(u), 32'h0);
        end
        bwrite(a_mask(3), 32'hFF);
        bwrite(a_pend(3), 32'h0);
        bread(a_pend(3), r);  check("R6 zero write keeps", r, 32'h4);
        check("R7 irq on", {28'h0, irq_o}, 32'h8);
        bwrite(a_pend(3), 32'h4);
        bread(a_pend(3), r);  check("R6 one clears", r, 32'h0);
        bread(a_pend(2), r);  check("R6 other user kept", r, 32'h4);
        check("R7 irq off", {28'h0, irq_o}, 32'h0);
        bwrite(a_mask(3), 32'h0);
        bread(a_data(1), r);  check("R1 drain", r, 32'h5555_0001);

        // R10: unmapped and misaligned accesses
        bwrite(9'h050, 32'hDEAD_BEEF);
        bwrite(9'h041, 32'hDEAD_BEEF);
        bwrite(9'h120, 32'hFFFF_FFFF);
        bread(9'h050, r);  check("R10 read gap", r, 32'h0);
        bread(9'h041, r);  check("R10 read misaligned", r, 32'h0);
        bread(9'h120, r);  check("R10 read past users", r, 32'h0);
        bread(9'h004, r);  check("R10 read low gap", r, 32'h0);
        for (int m = 0; m < NQ; m++) begin
            bread(a_lvl(m), r); check("R10 queues untouched", r, 32'h0);
        end

        // R9: idle fields read back
        bwrite(9'h010, 32'h0000_0011);
        bread(9'h010, r);  check("R9 config readback", r, 32'h11);

        // R8: reset sequence
        bwrite(a_data(2), 32'h1111_0000);
        bwrite(a_data(2), 32'h1111_0001);
        bwrite(a_mask(0), 32'hFF);
        check("R7 irq before reset", {28'h0, irq_o}, 32'h1);
        bwrite(9'h010, 32'h0000_0012);
        bread(9'h010, r);  check("R8 busy bit", r, 32'h12);
        bread(9'h014, r);  check("R8 done low", r, 32'h0);
        repeat (SRST) @(posedge clk);
        #1;
        bread(9'h014, r);  check("R8 done high", r, 32'h1);
        bread(9'h010, r);  check("R9 fields kept", r, 32'h10);
        bread(a_lvl(2), r); check("R8 queue emptied", r, 32'h0);
        bread(a_mask(0), r); check("R8 mask cleared", r, 32'h0);
        bread(a_pend(0), r); check("R8 pending cleared", r, 32'h0);
        check("R8 irq low", {28'h0, irq_o}, 32'h0);
        bwrite(a_data(2), 32'h2222_0000);
        bread(a_data(2), r); check("R8 usable after", r, 32'h2222_0000);

        report();
        $finish;
    end

endmodule